// File: doc/BRIEF.md
# Per-Port Destination MAC Filter

This block is the destination-address stage of a receive parser shared by several ingress ports. Each lookup presents the first six bytes of a frame, which are its destination MAC address, together with the ingress port number. One clock later the block returns an accept or drop verdict, the L2 cast class of the address, a flag that marks the port's own station address, and the number of header bytes the next parse stage must skip.

Filtering uses a table of masked address entries. Every entry carries a port bitmap, so one entry can serve several ports. Index 0 holds a drop-all entry. The specific address range follows it. The last two indices hold a unicast catch-all and a multicast catch-all, and their bitmaps give each port promiscuous reception for one address type.

A configuration port has three operations. The first writes any entry directly. The second adds an address for one port into the first free slot, and it applies per-port quotas for unicast and multicast. The third clears one port's entries. When a port goes over a quota, it is switched to the matching catch-all instead of receiving another entry.

Top module: `dmac_port_filter`

## Requirements
- R1: After reset, `res_done_o` and `cfg_err_o` are 0. All range entries are invalid. The drop-all entry and both catch-alls are valid but enable no port, so every lookup is dropped.
- R2: An entry hits only when it is valid, the bit for the ingress port is set in its port bitmap, and the address equals its stored data on every bit where its 48-bit mask is 1. The first address byte is `lkp_da_i[47:40]`.
- R3: `res_cast_o` encodes the class of the looked-up address: 2 when all 48 bits are 1 (broadcast), 1 when bit 40 is 1 (multicast), 0 otherwise (unicast). It is reported for accepted and dropped frames alike.
- R4: `res_to_me_o` is 1 only when the frame is accepted, its class is unicast, and the winning entry carries the own-address flag.
- R5: A pulse on `lkp_valid_i` gives `res_done_o` high for exactly the next cycle, with the results registered at that edge. `res_skip_o` is 12 on accept and 0 on drop.
- R6: When several entries hit, the lowest index wins. A win by index 0 (drop-all) drops the frame. When no entry hits, the frame is dropped.
- R7: With RANGE_SLOTS = S, index S+1 is the unicast catch-all (data bit 40 = 0, mask bit 40 only) and index S+2 is the multicast catch-all (data bit 40 = 1, mask bit 40 only). A port whose bit is set in one of them accepts every address of that type.
- R8: An add (`cfg_op_i` = 1) of a non-exempt address, when the port already holds its quota of that class (UC_QUOTA unicast, MC_QUOTA multicast), writes no entry. Instead it sets the port's bit in the matching catch-all and raises no error. An address is exempt when it is broadcast or carries the own flag, and an exempt add never counts against a quota.
- R9: An add that passes the quota check writes the entry, with a bitmap holding only `cfg_port_i`, into the lowest invalid index in 1..S. When no such index exists, `cfg_err_o` is 1 for the cycle after the add and nothing is written.
- R10: A clear (`cfg_op_i` = 2) removes port `cfg_port_i` from every range entry except broadcast entries and own-flag entries. An entry left with an empty bitmap becomes invalid. The clear also removes the port from both catch-alls and resets the port's quota counts.
- R11: An entry written valid with a zero port bitmap never hits, but it still occupies its slot for the add operation.
- R12: A write (`cfg_op_i` = 0) stores `cfg_valid_i`, data, mask, bitmap and own flag at `cfg_idx_i`. Writing valid 0 frees the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request pulse |
| lkp_port_i | input | PORT_W | Ingress port of the frame |
| lkp_da_i | input | 48 | Destination address, first byte in bits 47:40 |
| res_done_o | output | 1 | Result strobe, one cycle after the request |
| res_accept_o | output | 1 | 1 accept, 0 drop |
| res_cast_o | output | 2 | 0 unicast, 1 multicast, 2 broadcast |
| res_to_me_o | output | 1 | Accepted unicast on an own-address entry |
| res_skip_o | output | 4 | Header bytes to skip (12 or 0) |
| cfg_we_i | input | 1 | Configuration operation strobe |
| cfg_op_i | input | 2 | 0 write, 1 add, 2 clear |
| cfg_idx_i | input | IDX_W | Entry index for a write |
| cfg_port_i | input | PORT_W | Port for add and clear |
| cfg_valid_i | input | 1 | Valid bit for a write |
| cfg_own_i | input | 1 | Own-address flag |
| cfg_data_i | input | 48 | Address data |
| cfg_mask_i | input | 48 | Compare mask, 1 = compare bit |
| cfg_pmap_i | input | NUM_PORTS | Port bitmap for a write |
| cfg_err_o | output | 1 | Add found no free slot |

## Verification
The bench builds the block with two ports, a unicast quota of 2, a multicast quota of 1 and only six range slots. These small values let a short sequence fill the range completely and exercise the no-free-slot error. They also let one port exceed both its unicast and its multicast quota, so the fallback into each catch-all can be observed at the lookup port. After a clear frees slots, the bench re-adds addresses to show that the first free index is reused. The narrow range also shows that an inert entry with a zero bitmap still blocks an add.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned SKIP_W   = 4;
  localparam int unsigned HDR_SKIP = 12;

  typedef enum logic [1:0] {
    CAST_UNI   = 2'd0,
    CAST_MULTI = 2'd1,
    CAST_BROAD = 2'd2
  } cast_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ADD   = 2'd1,
    OP_CLEAR = 2'd2
  } op_e;

  function automatic cast_e cast_of(input logic [MAC_W-1:0] da);
    if (&da)        return CAST_BROAD;
    else if (da[40]) return CAST_MULTI;
    else            return CAST_UNI;
  endfunction
endpackage

// File: rtl/dmf_match.sv
module dmf_match
  import dmf_pkg::*;
#(
  parameter int unsigned NP = 4,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             vld_i,
  input  logic [MAC_W-1:0] data_i,
  input  logic [MAC_W-1:0] mask_i,
  input  logic [NP-1:0]    pmap_i,
  input  logic [MAC_W-1:0] da_i,
  input  logic [PW-1:0]    port_i,
  output logic             hit_o
);
  logic addr_eq;
  assign addr_eq = ((da_i ^ data_i) & mask_i) == '0;
  assign hit_o   = vld_i && pmap_i[port_i] && addr_eq;
endmodule

// File: rtl/dmf_prio.sv
module dmf_prio #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dmf_table.sv
module dmf_table
  import dmf_pkg::*;
#(
  parameter int unsigned NP  = 4,
  parameter int unsigned UCQ = 4,
  parameter int unsigned MCQ = 21,
  parameter int unsigned RS  = 105,
  localparam int unsigned NE = RS + 3,
  localparam int unsigned IW = $clog2(NE),
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_op_i,
  input  logic [IW-1:0]           cfg_idx_i,
  input  logic [PW-1:0]           cfg_port_i,
  input  logic                    cfg_valid_i,
  input  logic                    cfg_own_i,
  input  logic [MAC_W-1:0]        cfg_data_i,
  input  logic [MAC_W-1:0]        cfg_mask_i,
  input  logic [NP-1:0]           cfg_pmap_i,
  output logic                    cfg_err_o,
  output logic [NE-1:0]           ent_vld_o,
  output logic [NE-1:0]           ent_own_o,
  output logic [NE-1:0][MAC_W-1:0] ent_data_o,
  output logic [NE-1:0][MAC_W-1:0] ent_mask_o,
  output logic [NE-1:0][NP-1:0]   ent_pmap_o
);
  localparam int unsigned UC_IDX = RS + 1;
  localparam int unsigned MC_IDX = RS + 2;
  localparam int unsigned QMAX   = (UCQ > MCQ) ? UCQ : MCQ;
  localparam int unsigned CW     = $clog2(QMAX + 1);
  localparam logic [MAC_W-1:0] GRP_BIT = MAC_W'(1) << 40;

  logic [NP-1:0][CW-1:0] uc_cnt, mc_cnt;
  logic [NP-1:0]         port_bit;
  logic                  free_found;
  logic [IW-1:0]         free_idx;
  logic                  add_multi, add_exempt, quota_full;
  logic                  do_write, do_add, do_clear;

  assign do_write = cfg_we_i && (cfg_op_i == OP_WRITE);
  assign do_add   = cfg_we_i && (cfg_op_i == OP_ADD);
  assign do_clear = cfg_we_i && (cfg_op_i == OP_CLEAR);

  always_comb begin
    port_bit = '0;
    port_bit[cfg_port_i] = 1'b1;
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = RS; i >= 1; i--) begin
      if (!ent_vld_o[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign add_multi  = cfg_data_i[40];
  assign add_exempt = cfg_own_i || (&cfg_data_i);
  assign quota_full = !add_exempt &&
                      (add_multi ? (mc_cnt[cfg_port_i] == CW'(MCQ))
                                 : (uc_cnt[cfg_port_i] == CW'(UCQ)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) begin
        ent_vld_o[i]  <= (i == 0) || (i == UC_IDX) || (i == MC_IDX);
        ent_own_o[i]  <= 1'b0;
        ent_data_o[i] <= (i == MC_IDX) ? GRP_BIT : '0;
        ent_mask_o[i] <= ((i == UC_IDX) || (i == MC_IDX)) ? GRP_BIT : '0;
        ent_pmap_o[i] <= '0;
      end
      uc_cnt    <= '0;
      mc_cnt    <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      cfg_err_o <= 1'b0;
      if (do_write && (int'(cfg_idx_i) < NE)) begin
        ent_vld_o[cfg_idx_i]  <= cfg_valid_i;
        ent_own_o[cfg_idx_i]  <= cfg_own_i;
        ent_data_o[cfg_idx_i] <= cfg_data_i;
        ent_mask_o[cfg_idx_i] <= cfg_mask_i;
        ent_pmap_o[cfg_idx_i] <= cfg_pmap_i;
      end
      if (do_add) begin
        if (quota_full) begin
          if (add_multi) ent_pmap_o[MC_IDX][cfg_port_i] <= 1'b1;
          else           ent_pmap_o[UC_IDX][cfg_port_i] <= 1'b1;
        end else if (free_found) begin
          ent_vld_o[free_idx]  <= 1'b1;
          ent_own_o[free_idx]  <= cfg_own_i;
          ent_data_o[free_idx] <= cfg_data_i;
          ent_mask_o[free_idx] <= cfg_mask_i;
          ent_pmap_o[free_idx] <= port_bit;
          if (!add_exempt) begin
            if (add_multi) mc_cnt[cfg_port_i] <= mc_cnt[cfg_port_i] + 1'b1;
            else           uc_cnt[cfg_port_i] <= uc_cnt[cfg_port_i] + 1'b1;
          end
        end else begin
          cfg_err_o <= 1'b1;
        end
      end
      if (do_clear) begin
        for (int i = 1; i <= RS; i++) begin
          if (ent_vld_o[i] && ent_pmap_o[i][cfg_port_i] &&
              !ent_own_o[i] && !(&ent_data_o[i])) begin
            ent_pmap_o[i][cfg_port_i] <= 1'b0;
            if (ent_pmap_o[i] == port_bit) ent_vld_o[i] <= 1'b0;
          end
        end
        ent_pmap_o[UC_IDX][cfg_port_i] <= 1'b0;
        ent_pmap_o[MC_IDX][cfg_port_i] <= 1'b0;
        uc_cnt[cfg_port_i] <= '0;
        mc_cnt[cfg_port_i] <= '0;
      end
    end
  end

  AST_ERR_AFTER_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(do_add)) else $error("err without add"); // R9

  AST_ERR_MEANS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_add && !quota_full && !free_found) |=> cfg_err_o) else $error("full add not flagged"); // R9

  for (genvar p = 0; p < NP; p++) begin : g_cnt_chk
    AST_UC_QUOTA_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uc_cnt[p] <= CW'(UCQ)) else $error("uc quota overrun"); // R8
    AST_MC_QUOTA_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mc_cnt[p] <= CW'(MCQ)) else $error("mc quota overrun"); // R8
  end
endmodule

// File: rtl/dmac_port_filter.sv
module dmac_port_filter
  import dmf_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned UC_QUOTA    = 4,
  parameter int unsigned MC_QUOTA    = 21,
  parameter int unsigned RANGE_SLOTS = NUM_PORTS * (UC_QUOTA + MC_QUOTA) + NUM_PORTS + 1,
  localparam int unsigned NUM_ENT    = RANGE_SLOTS + 3,
  localparam int unsigned IDX_W      = $clog2(NUM_ENT),
  localparam int unsigned PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lkp_valid_i,
  input  logic [PORT_W-1:0]    lkp_port_i,
  input  logic [47:0]          lkp_da_i,
  output logic                 res_done_o,
  output logic                 res_accept_o,
  output logic [1:0]           res_cast_o,
  output logic                 res_to_me_o,
  output logic [3:0]           res_skip_o,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_op_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [PORT_W-1:0]    cfg_port_i,
  input  logic                 cfg_valid_i,
  input  logic                 cfg_own_i,
  input  logic [47:0]          cfg_data_i,
  input  logic [47:0]          cfg_mask_i,
  input  logic [NUM_PORTS-1:0] cfg_pmap_i,
  output logic                 cfg_err_o
);
  logic [NUM_ENT-1:0]            ent_vld, ent_own, hit;
  logic [NUM_ENT-1:0][MAC_W-1:0] ent_data, ent_mask;
  logic [NUM_ENT-1:0][NUM_PORTS-1:0] ent_pmap;
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic             accept_c;
  cast_e            cast_c;

  dmf_table #(
    .NP (NUM_PORTS), .UCQ(UC_QUOTA), .MCQ(MC_QUOTA), .RS(RANGE_SLOTS)
  ) u_table (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_op_i, .cfg_idx_i, .cfg_port_i, .cfg_valid_i,
    .cfg_own_i, .cfg_data_i, .cfg_mask_i, .cfg_pmap_i, .cfg_err_o,
    .ent_vld_o (ent_vld),
    .ent_own_o (ent_own),
    .ent_data_o(ent_data),
    .ent_mask_o(ent_mask),
    .ent_pmap_o(ent_pmap)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    dmf_match #(.NP(NUM_PORTS)) u_match (
      .vld_i (ent_vld[e]),
      .data_i(ent_data[e]),
      .mask_i(ent_mask[e]),
      .pmap_i(ent_pmap[e]),
      .da_i  (lkp_da_i),
      .port_i(lkp_port_i),
      .hit_o (hit[e])
    );
  end

  dmf_prio #(.N(NUM_ENT)) u_prio (
    .hit_i  (hit),
    .found_o(win_found),
    .idx_o  (win_idx)
  );

  // index 0 is the drop-all entry
  assign accept_c = win_found && (win_idx != '0);
  assign cast_c   = cast_of(lkp_da_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_done_o   <= 1'b0;
      res_accept_o <= 1'b0;
      res_cast_o   <= CAST_UNI;
      res_to_me_o  <= 1'b0;
      res_skip_o   <= '0;
    end else begin
      res_done_o <= lkp_valid_i;
      if (lkp_valid_i) begin
        res_accept_o <= accept_c;
        res_cast_o   <= cast_c;
        res_to_me_o  <= accept_c && ent_own[win_idx] && (cast_c == CAST_UNI);
        res_skip_o   <= accept_c ? SKIP_W'(HDR_SKIP) : '0;
      end
    end
  end

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> res_done_o) else $error("missing done"); // R5

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !res_done_o) else $error("spurious done"); // R5

  AST_TO_ME_UNICAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_to_me_o |-> (res_accept_o && res_cast_o == CAST_UNI)) else $error("bad to_me"); // R4

  AST_DROP_ALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && ent_vld[0] && ent_pmap[0][lkp_port_i]) |=> !res_accept_o)
    else $error("drop-all bypassed"); // R6

  AST_SKIP_TRACKS_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_done_o |-> (res_accept_o == (res_skip_o != '0))) else $error("skip mismatch"); // R5
endmodule

// File: tb/tb_dmac_port_filter.sv
module tb_dmac_port_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int RS = 6;
  localparam int IW = $clog2(RS + 3);

  localparam logic [47:0] BC   = 48'hffff_ffff_ffff;
  localparam logic [47:0] FULL = 48'hffff_ffff_ffff;
  localparam logic [47:0] GRP  = 48'h0100_0000_0000;
  localparam logic [47:0] OWN0 = 48'h0200_0000_0010;
  localparam logic [47:0] OWN1 = 48'h0200_0000_0011;
  localparam logic [47:0] U1   = 48'h0200_0000_0021;
  localparam logic [47:0] U2   = 48'h0200_0000_0022;
  localparam logic [47:0] U3   = 48'h0200_0000_0023;
  localparam logic [47:0] U4   = 48'h0200_0000_0024;
  localparam logic [47:0] U5   = 48'h0200_0000_0025;
  localparam logic [47:0] M1   = 48'h0100_5e00_0001;
  localparam logic [47:0] M2   = 48'h0100_5e00_0002;

  logic clk = 0, rst_n = 0;
  logic lkp_valid = 0; logic lkp_port = 0; logic [47:0] lkp_da = '0;
  logic res_done, res_accept, res_to_me; logic [1:0] res_cast; logic [3:0] res_skip;
  logic cfg_we = 0; logic [1:0] cfg_op = 0; logic [IW-1:0] cfg_idx = 0;
  logic cfg_port = 0, cfg_valid = 0, cfg_own = 0;
  logic [47:0] cfg_data = 0, cfg_mask = 0; logic [NP-1:0] cfg_pmap = 0;
  logic cfg_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_port_filter #(.NUM_PORTS(NP), .UC_QUOTA(2), .MC_QUOTA(1), .RANGE_SLOTS(RS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_port_i(lkp_port), .lkp_da_i(lkp_da),
    .res_done_o(res_done), .res_accept_o(res_accept), .res_cast_o(res_cast),
    .res_to_me_o(res_to_me), .res_skip_o(res_skip),
    .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_idx_i(cfg_idx), .cfg_port_i(cfg_port),
    .cfg_valid_i(cfg_valid), .cfg_own_i(cfg_own), .cfg_data_i(cfg_data),
    .cfg_mask_i(cfg_mask), .cfg_pmap_i(cfg_pmap), .cfg_err_o(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected word: {accept, cast[1:0], to_me, skip[3:0]}
  task automatic lookup(input logic p, input logic [47:0] da, input logic acc,
                        input logic [1:0] cast, input logic me, input string tag);
    item_t it;
    it.exp = {acc, cast, me, acc ? 4'd12 : 4'd0};
    it.tag = tag;
    @(negedge clk);
    lkp_valid = 1; lkp_port = p; lkp_da = da;
    sb_q.push_back(it);
    @(negedge clk);
    lkp_valid = 0;
  endtask

  task automatic cfg(input logic [1:0] op, input int idx, input logic [47:0] data,
                     input logic [47:0] mask, input logic [NP-1:0] pmap,
                     input logic own, input logic p, input logic vld);
    @(negedge clk);
    cfg_we = 1; cfg_op = op; cfg_idx = IW'(idx); cfg_data = data; cfg_mask = mask;
    cfg_pmap = pmap; cfg_own = own; cfg_port = p; cfg_valid = vld;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic add(input logic p, input logic [47:0] da, input logic own);
    cfg(2'd1, 0, da, FULL, '0, own, p, 1'b0);
  endtask

  task automatic chk_err(input logic exp, input string tag);
    check(cfg_err == exp, tag, {7'd0, cfg_err}, {7'd0, exp});
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R5 unexpected done", 8'd1, 8'd0);
        end else begin
          item_t it;
          logic [7:0] act;
          it = sb_q.pop_front();
          act = {res_accept, res_cast, res_to_me, res_skip};
          check(act == it.exp, it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 8'd0, 8'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_done == 0, "R1 done after reset", {7'd0, res_done}, 8'd0);
    check(cfg_err == 0, "R1 err after reset", {7'd0, cfg_err}, 8'd0);
    rst_n = 1;
    lookup(0, U1, 0, 2'd0, 0, "R1 empty table drops");
    lookup(1, M1, 0, 2'd1, 0, "R1 no catch-all at reset");

    cfg(2'd0, 1, BC, FULL, 2'b11, 0, 0, 1);
    add(0, OWN0, 1);
    add(1, OWN1, 1);
    lookup(0, BC, 1, 2'd2, 0, "R3 broadcast p0");
    lookup(1, BC, 1, 2'd2, 0, "R3 broadcast p1");
    lookup(0, OWN0, 1, 2'd0, 1, "R4 own addr p0");
    lookup(1, OWN0, 0, 2'd0, 0, "R2 bitmap excludes p1");
    lookup(1, OWN1, 1, 2'd0, 1, "R4 own addr p1");

    add(0, U1, 0);
    add(0, U2, 0);
    lookup(0, U1, 1, 2'd0, 0, "R9 add fills slot");
    add(0, U3, 0);
    chk_err(0, "R8 uc fallback no err");
    lookup(0, U3, 1, 2'd0, 0, "R8 uc over quota via catch-all");
    lookup(0, 48'h0200_0000_0099, 1, 2'd0, 0, "R7 uc promisc unknown");
    lookup(1, U3, 0, 2'd0, 0, "R8 fallback only for p0");
    lookup(0, M1, 0, 2'd1, 0, "R7 uc catch-all ignores mc");

    add(1, M1, 0);
    lookup(1, M1, 1, 2'd1, 0, "R3 multicast p1");
    lookup(0, M1, 0, 2'd1, 0, "R2 mc entry p1 only");
    add(1, U1, 0);
    chk_err(1, "R9 full table err");
    lookup(1, U1, 0, 2'd0, 0, "R9 full add not written");
    add(1, M2, 0);
    chk_err(0, "R8 mc fallback no err");
    lookup(1, M2, 1, 2'd1, 0, "R8 mc over quota via catch-all");
    lookup(1, 48'h0100_5e00_0077, 1, 2'd1, 0, "R7 mc promisc unknown");
    lookup(0, M2, 0, 2'd1, 0, "R8 mc fallback only for p1");

    cfg(2'd0, 0, '0, '0, 2'b10, 0, 0, 1);
    lookup(1, OWN1, 0, 2'd0, 0, "R6 drop-all beats own");
    lookup(1, BC, 0, 2'd2, 0, "R6 drop-all beats bcast");
    lookup(0, BC, 1, 2'd2, 0, "R6 drop-all p0 unaffected");
    cfg(2'd0, 0, '0, '0, 2'b00, 0, 0, 1);
    lookup(1, OWN1, 1, 2'd0, 1, "R11 zero bitmap drop-all inert");

    cfg(2'd2, 0, '0, '0, '0, 0, 0, 0);
    lookup(0, U1, 0, 2'd0, 0, "R10 clear removes uc");
    lookup(0, U3, 0, 2'd0, 0, "R10 clear withdraws catch-all");
    lookup(0, BC, 1, 2'd2, 0, "R10 bcast kept");
    lookup(0, OWN0, 1, 2'd0, 1, "R10 own kept");
    lookup(1, M1, 1, 2'd1, 0, "R10 other port kept");
    lookup(1, M2, 1, 2'd1, 0, "R10 other port promisc kept");

    add(1, U4, 0);
    chk_err(0, "R9 freed slot reused");
    lookup(1, U4, 1, 2'd0, 0, "R9 re-added entry hits");

    cfg(2'd0, 5, U1, FULL, 2'b00, 0, 0, 1);
    lookup(0, U1, 0, 2'd0, 0, "R11 zero bitmap no hit p0");
    lookup(1, U1, 0, 2'd0, 0, "R11 zero bitmap no hit p1");
    add(1, U5, 0);
    chk_err(1, "R11 inert entry occupies slot");

    cfg(2'd0, 4, 48'h0200_0000_0040, FULL, 2'b11, 0, 0, 1);
    cfg(2'd0, 5, 48'h0200_0000_0000, 48'hffff_ffff_ff00, 2'b11, 1, 0, 1);
    lookup(1, 48'h0200_0000_0040, 1, 2'd0, 0, "R6 lowest index wins");
    lookup(1, 48'h0200_0000_0041, 1, 2'd0, 1, "R2 masked byte match");

    cfg(2'd0, RS + 2, GRP, GRP, 2'b01, 0, 0, 1);
    lookup(0, 48'h0180_c200_000e, 1, 2'd1, 0, "R7 mc catch-all written p0");
    lookup(0, 48'h0200_0000_0177, 0, 2'd0, 0, "R7 uc not promisc p0");
    cfg(2'd0, 6, '0, '0, '0, 0, 0, 0);
    lookup(1, M1, 0, 2'd1, 0, "R12 write valid 0 frees");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R5 all results seen", 8'(sb_q.size()), 8'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule